// File: doc/BRIEF.md
# Double-Precision Special-Operand Exception Detector

This block looks at the two 64-bit IEEE-754 double operands and the opcode of a floating-point operation. It decides whether the operation hits a special case that must not go through the normal arithmetic datapath. The opcodes are add, subtract, multiply, divide and conversion to a 32-bit integer. The block reports the invalid-operation causes and a divide-by-zero flag. It drives a pass-through signal that tells the normal datapath to compute the result. When the matching trap enable is off, it also supplies the 64-bit result that replaces the one the operation would have written.

The checks follow a fixed priority. A signaling NaN operand is checked first. The opcode-specific infinity and zero combinations come after it. For conversions that succeed, the block forms the 64-bit result itself: the converter's 32-bit value goes in the low half, and the high half carries a fixed fill pattern. The cause bits and the zero-divide flag go to a separate status-register controller. All outputs are registered once and qualified by `vld_o`.

Top module: `fp_special_det`

## Requirements
- R1: Operand classes come from the exponent field and the top fraction bit. An all-ones exponent with a zero fraction is infinity. An all-ones exponent with a nonzero fraction is a quiet NaN when the top fraction bit is 1 and a signaling NaN when it is 0. A zero exponent with a zero fraction is zero, whatever the sign.
- R2: For opcodes add (0), subtract (1), multiply (2) and divide (3), a signaling NaN in either operand sets only cause bit 0 (signaling NaN), ahead of every other check.
- R3: Add with two infinities of opposite sign, or subtract with two infinities of the same sign, sets only cause bit 1 (infinity minus infinity).
- R4: Multiply of zero by infinity, in either operand order, sets only cause bit 4 (zero times infinity).
- R5: Divide of infinity by infinity sets only cause bit 2. Divide of zero by zero sets only cause bit 3.
- R6: Divide of any other operand, including infinity or a quiet NaN, by zero sets `zx_o` and no cause bit.
- R7: On a zero-divide with `zdiv_en_i` low, `subst_o` is 1 and `result_o` is an infinity with the XOR of the operand signs as its sign, an exponent of all ones and a zero fraction. With `zdiv_en_i` high, `subst_o` is 0.
- R8: `vx_o` is the OR of the cause bits. On any invalid cause with `inv_en_i` low, `subst_o` is 1 and `result_o` is all ones. With `inv_en_i` high, `subst_o` is 0.
- R9: For convert (4), only operand A is checked. A signaling NaN sets cause bits 0 and 5. A quiet NaN or an infinity sets only cause bit 5 (invalid conversion).
- R10: A convert with no special case gives `subst_o`=1 and `result_o` = {32'hFFF80000, `cvt_lo_i`}.
- R11: `pass_o` is 1 exactly when there is no cause bit and no zero-divide. Opcodes 5 to 7 never flag and always pass. Whenever `subst_o` is 0, `result_o` is zero.
- R12: The outputs reflect the inputs sampled at the previous rising clock edge. When `valid_i` was low, or during reset, `vld_o`, all flags, `subst_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | 0 add, 1 subtract, 2 multiply, 3 divide, 4 convert to int32 |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (ignored for convert) |
| cvt_lo_i | input | 32 | Integer from the converter, for a successful convert |
| inv_en_i | input | 1 | Invalid-operation trap enable |
| zdiv_en_i | input | 1 | Zero-divide trap enable |
| vld_o | output | 1 | Outputs valid |
| pass_o | output | 1 | No special case; normal datapath computes |
| subst_o | output | 1 | result_o replaces the operation result |
| vx_o | output | 1 | Any invalid cause |
| zx_o | output | 1 | Divide by zero |
| cause_o | output | 6 | Invalid causes: 0 sNaN, 1 inf-inf, 2 inf/inf, 3 0/0, 4 0*inf, 5 bad convert |
| result_o | output | 64 | Substituted or formed result |

## Verification
The assertions check the properties that hold on every cycle. At most one arithmetic cause is set at a time. Zero-divide and invalid never occur together, and pass excludes both. An idle cycle leaves every output at zero. The shape of the substituted result follows from the flag it came with, and the one-cycle latency holds. Only the bench's scenarios can show that a given operand pair and opcode produce the right cause, because that depends on the priority order and on the operand classes. These scenarios cover the signaling NaN that wins over infinity checks, a quiet NaN divided by zero that counts as a zero-divide, and negative zero that counts as zero.

// File: rtl/fpsx_pkg.sv
package fpsx_pkg;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int CVT_W   = 32;
  localparam int N_CAUSE = 6;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_MUL = 3'd2;
  localparam logic [2:0] OP_DIV = 3'd3;
  localparam logic [2:0] OP_CVT = 3'd4;

  localparam int C_SNAN = 0;
  localparam int C_ISI  = 1;
  localparam int C_IDI  = 2;
  localparam int C_ZDZ  = 3;
  localparam int C_IMZ  = 4;
  localparam int C_CVI  = 5;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic qnan;
    logic snan;
  } fcls_t;

  typedef struct packed {
    logic [N_CAUSE-1:0] cause;
    logic               zdiv;
  } flags_t;
endpackage

// File: rtl/fpsx_classify.sv
module fpsx_classify
  import fpsx_pkg::*;
#(
  parameter int EXP_W_P  = EXP_W,
  parameter int FRAC_W_P = FRAC_W,
  localparam int W = 1 + EXP_W_P + FRAC_W_P
) (
  input  logic [W-1:0] val_i,
  output fcls_t        cls_o
);
  logic [EXP_W_P-1:0]  exp_f;
  logic [FRAC_W_P-1:0] frac_f;
  logic exp_max, exp_min, frac_nz;

  assign exp_f   = val_i[W-2 -: EXP_W_P];
  assign frac_f  = val_i[FRAC_W_P-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls_o      = '0;
    cls_o.sign = val_i[W-1];
    cls_o.zero = exp_min & ~frac_nz;
    cls_o.inf  = exp_max & ~frac_nz;
    cls_o.qnan = exp_max & frac_nz &  frac_f[FRAC_W_P-1];
    cls_o.snan = exp_max & frac_nz & ~frac_f[FRAC_W_P-1];
  end

  always_comb begin
    assert ($countones({cls_o.zero, cls_o.inf, cls_o.qnan, cls_o.snan}) <= 1)
      else $error("p_class_excl_r1");
  end
endmodule

// File: rtl/fpsx_decode.sv
module fpsx_decode
  import fpsx_pkg::*;
(
  input  logic [2:0] op_i,
  input  fcls_t      cls_a_i,
  input  fcls_t      cls_b_i,
  output flags_t     flags_o
);
  logic any_snan;
  logic unused_b_qnan;

  assign any_snan      = cls_a_i.snan | cls_b_i.snan;
  assign unused_b_qnan = cls_b_i.qnan;

  always_comb begin
    flags_o = '0;
    case (op_i)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
        if (any_snan) begin
          flags_o.cause[C_SNAN] = 1'b1;
        end else begin
          case (op_i)
            OP_ADD:
              flags_o.cause[C_ISI] = cls_a_i.inf & cls_b_i.inf & (cls_a_i.sign ^ cls_b_i.sign);
            OP_SUB:
              flags_o.cause[C_ISI] = cls_a_i.inf & cls_b_i.inf & ~(cls_a_i.sign ^ cls_b_i.sign);
            OP_MUL:
              flags_o.cause[C_IMZ] = (cls_a_i.inf & cls_b_i.zero) | (cls_a_i.zero & cls_b_i.inf);
            default: begin
              if (cls_a_i.inf && cls_b_i.inf) flags_o.cause[C_IDI] = 1'b1;
              else if (cls_b_i.zero) begin
                if (cls_a_i.zero) flags_o.cause[C_ZDZ] = 1'b1;
                else              flags_o.zdiv = 1'b1;
              end
            end
          endcase
        end
      end
      OP_CVT: begin
        flags_o.cause[C_SNAN] = cls_a_i.snan;
        flags_o.cause[C_CVI]  = cls_a_i.snan | cls_a_i.qnan | cls_a_i.inf;
      end
      default: flags_o = '0;
    endcase
  end

  always_comb begin
    assert (!(flags_o.zdiv && (op_i != OP_DIV))) else $error("p_zdiv_div_only_r6");
  end
endmodule

// File: rtl/fpsx_subst.sv
module fpsx_subst
  import fpsx_pkg::*;
#(
  parameter int EXP_W_P  = EXP_W,
  parameter int FRAC_W_P = FRAC_W,
  parameter int CVT_W_P  = CVT_W,
  localparam int W    = 1 + EXP_W_P + FRAC_W_P,
  localparam int HI_W = W - CVT_W_P
) (
  input  logic [2:0]         op_i,
  input  flags_t             flags_i,
  input  logic               sign_a_i,
  input  logic               sign_b_i,
  input  logic [CVT_W_P-1:0] cvt_lo_i,
  input  logic               inv_en_i,
  input  logic               zdiv_en_i,
  output logic               pass_o,
  output logic               subst_o,
  output logic               vx_o,
  output logic [W-1:0]       result_o
);
  // high half of a converted word: negative quiet-NaN prefix
  localparam logic [W-1:0] NEG_QNAN = {1'b1, {EXP_W_P{1'b1}}, 1'b1, {(FRAC_W_P-1){1'b0}}};
  localparam logic [HI_W-1:0] CVT_FILL = NEG_QNAN[W-1 -: HI_W];

  assign vx_o   = |flags_i.cause;
  assign pass_o = ~vx_o & ~flags_i.zdiv;

  always_comb begin
    subst_o  = 1'b0;
    result_o = '0;
    if (vx_o) begin
      subst_o  = ~inv_en_i;
      result_o = inv_en_i ? '0 : '1;
    end else if (flags_i.zdiv) begin
      subst_o  = ~zdiv_en_i;
      result_o = zdiv_en_i ? '0 : {sign_a_i ^ sign_b_i, {EXP_W_P{1'b1}}, {FRAC_W_P{1'b0}}};
    end else if (op_i == OP_CVT) begin
      subst_o  = 1'b1;
      result_o = {CVT_FILL, cvt_lo_i};
    end
  end
endmodule

// File: rtl/fp_special_det.sv
module fp_special_det
  import fpsx_pkg::*;
#(
  parameter int EXP_W_P  = EXP_W,
  parameter int FRAC_W_P = FRAC_W,
  parameter int CVT_W_P  = CVT_W,
  localparam int W = 1 + EXP_W_P + FRAC_W_P
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           op_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic [CVT_W_P-1:0]   cvt_lo_i,
  input  logic                 inv_en_i,
  input  logic                 zdiv_en_i,
  output logic                 vld_o,
  output logic                 pass_o,
  output logic                 subst_o,
  output logic                 vx_o,
  output logic                 zx_o,
  output logic [N_CAUSE-1:0]   cause_o,
  output logic [W-1:0]         result_o
);
  fcls_t cls [2];
  logic [W-1:0] opnd [2];
  flags_t flags;
  logic pass_d, subst_d, vx_d;
  logic [W-1:0] result_d;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpsx_classify #(.EXP_W_P(EXP_W_P), .FRAC_W_P(FRAC_W_P)) u_cls (
      .val_i (opnd[g]),
      .cls_o (cls[g])
    );
  end

  fpsx_decode u_dec (
    .op_i    (op_i),
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .flags_o (flags)
  );

  fpsx_subst #(.EXP_W_P(EXP_W_P), .FRAC_W_P(FRAC_W_P), .CVT_W_P(CVT_W_P)) u_sub (
    .op_i      (op_i),
    .flags_i   (flags),
    .sign_a_i  (cls[0].sign),
    .sign_b_i  (cls[1].sign),
    .cvt_lo_i  (cvt_lo_i),
    .inv_en_i  (inv_en_i),
    .zdiv_en_i (zdiv_en_i),
    .pass_o    (pass_d),
    .subst_o   (subst_d),
    .vx_o      (vx_d),
    .result_o  (result_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      pass_o   <= 1'b0;
      subst_o  <= 1'b0;
      vx_o     <= 1'b0;
      zx_o     <= 1'b0;
      cause_o  <= '0;
      result_o <= '0;
    end else begin
      vld_o    <= valid_i;
      pass_o   <= valid_i & pass_d;
      subst_o  <= valid_i & subst_d;
      vx_o     <= valid_i & vx_d;
      zx_o     <= valid_i & flags.zdiv;
      cause_o  <= valid_i ? flags.cause : '0;
      result_o <= valid_i ? result_d : '0;
    end
  end

  p_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> vld_o);
  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> !pass_o && !subst_o && !vx_o && !zx_o && result_o == '0);
  p_arith_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o[C_IMZ:C_ISI]));
  p_pass_clean_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> !vx_o && !zx_o && cause_o == '0);
  p_zx_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zx_o |-> !vx_o && vld_o);
  p_nan_subst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (subst_o && vx_o) |-> result_o == '1);
  p_inf_subst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (subst_o && zx_o) |-> (&result_o[W-2 -: EXP_W_P]) && result_o[FRAC_W_P-1:0] == '0);
  p_nosubst_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !subst_o |-> result_o == '0);
endmodule

// File: tb/fp_special_det_tb.sv
module fp_special_det_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] op = '0;
  logic [63:0] a = '0, b = '0;
  logic [31:0] lo = '0;
  logic inv_en = 1'b0, zd_en = 1'b0;
  logic vld, pass, subst, vx, zx;
  logic [5:0] cause;
  logic [63:0] res;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  fp_special_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .cvt_lo_i(lo), .inv_en_i(inv_en), .zdiv_en_i(zd_en), .vld_o(vld), .pass_o(pass),
    .subst_o(subst), .vx_o(vx), .zx_o(zx), .cause_o(cause), .result_o(res)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] opv(input int k);
    case (k)
      0: return 64'h0000_0000_0000_0000;  // +0
      1: return 64'h8000_0000_0000_0000;  // -0
      2: return 64'h3FF0_0000_0000_0000;  // +1.0
      3: return 64'hC004_0000_0000_0000;  // -2.5
      4: return 64'h7FF0_0000_0000_0000;  // +inf
      5: return 64'hFFF0_0000_0000_0000;  // -inf
      6: return 64'h7FF8_0000_0000_0000;  // qNaN
      default: return 64'h7FF0_0000_0000_0001;  // sNaN
    endcase
  endfunction

  task automatic apply(input int o, input logic [63:0] va, input logic [63:0] vb,
                       input logic ie, input logic ze, input logic [31:0] l);
    @(negedge clk);
    valid = 1'b1; op = 3'(o); a = va; b = vb; inv_en = ie; zd_en = ze; lo = l;
    @(negedge clk);
  endtask

  task automatic sweep_one(input int o, input int ka, input int kb, input int en);
    bit za, zb, ia, ib, qa, sa, sb, sga, sgb;
    logic [5:0] ec;
    logic ez, ep, es;
    logic [63:0] er;
    logic [31:0] l;
    string ct, rt;
    za = ka < 2; zb = kb < 2; ia = ka == 4 || ka == 5; ib = kb == 4 || kb == 5;
    qa = ka == 6; sa = ka == 7; sb = kb == 7;
    sga = ka == 1 || ka == 3 || ka == 5; sgb = kb == 1 || kb == 3 || kb == 5;
    l = 32'hA5C3_0000 ^ 32'((o << 12) | (ka << 8) | (kb << 4) | en);
    ec = '0; ez = 1'b0; ct = "R11";
    if (o <= 3 && (sa || sb)) begin ec[0] = 1'b1; ct = "R2"; end
    else if (o == 0) begin ct = "R3"; ec[1] = ia && ib && (sga != sgb); end
    else if (o == 1) begin ct = "R3"; ec[1] = ia && ib && (sga == sgb); end
    else if (o == 2) begin ct = "R4"; ec[4] = (ia && zb) || (za && ib); end
    else if (o == 3) begin
      ct = "R5";
      if (ia && ib) ec[2] = 1'b1;
      else if (zb && za) ec[3] = 1'b1;
      else if (zb) ez = 1'b1;
    end else if (o == 4) begin
      ct = "R9"; ec[0] = sa; ec[5] = sa || qa || ia;
    end
    ep = (ec == 0) && !ez;
    es = 1'b0; er = '0; rt = "R11";
    if (ec != 0) begin rt = "R8"; es = !en[0]; er = es ? '1 : '0; end
    else if (ez) begin rt = "R7"; es = !en[1]; er = es ? {sga ^ sgb, 11'h7FF, 52'h0} : '0; end
    else if (o == 4) begin rt = "R10"; es = 1'b1; er = {32'hFFF8_0000, l}; end
    apply(o, opv(ka), opv(kb), en[0], en[1], l);
    chk("R12", "vld", 64'(vld), 64'd1);
    chk(ct, "cause", 64'(cause), 64'(ec));
    chk("R8", "vx", 64'(vx), 64'(ec != 0));
    chk("R6", "zx", 64'(zx), 64'(ez));
    chk("R11", "pass", 64'(pass), 64'(ep));
    chk(rt, "subst", 64'(subst), 64'(es));
    chk(rt, "result", res, er);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "reset vld", 64'(vld), 64'd0);
    chk("R12", "reset result", res, 64'd0);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int ka = 0; ka < 8; ka++)
        for (int kb = 0; kb < 8; kb++)
          for (int en = 0; en < 4; en++)
            sweep_one(o, ka, kb, en);
    // R1: sNaN with clear top fraction bit but other bits set
    apply(0, 64'h7FF4_0000_0000_0000, opv(2), 1'b0, 1'b0, '0);
    chk("R1", "snan class", 64'(cause), 64'h01);
    // R1: negative quiet NaN is not signaling
    apply(0, 64'hFFF8_0000_0000_0000, opv(2), 1'b0, 1'b0, '0);
    chk("R1", "qnan class", 64'(pass), 64'd1);
    // R1: a denormal divisor is not zero
    apply(3, opv(2), 64'h0000_0000_0000_0001, 1'b0, 1'b0, '0);
    chk("R1", "denorm not zero", 64'(zx), 64'd0);
    // R1, R7: divide by negative zero gives negative infinity
    apply(3, opv(2), opv(1), 1'b0, 1'b0, '0);
    chk("R1", "neg zero divisor", res, 64'hFFF0_0000_0000_0000);
    // R12: idle cycle clears outputs
    @(negedge clk); valid = 1'b0; op = 3'd4;
    @(negedge clk);
    chk("R12", "idle vld", 64'(vld), 64'd0);
    chk("R12", "idle subst", 64'(subst), 64'd0);
    chk("R12", "idle result", res, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule